// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out one atomic memory operation of a bytecode machine at a time. It works against a single-port synchronous memory, where read data appears one cycle after the read request. A start strobe captures the inputs: a base address and a signed 16-bit displacement, the value of the source register, the value of R0, the two-bit access-size code and the 32-bit operation immediate. The unit then reads the addressed double-word, computes the new value and writes it back. It raises a lock output for the whole read-then-write window so that no other agent can reach the same memory in between.

When the operation is finished the unit gives a one-cycle done strobe. Where the operation calls for it, the unit also returns a writeback value and a flag that says which register takes it: the source register for fetching operations, and R0 for compare-exchange. A request with an unsupported size or operation code gives a done strobe with an error flag and touches no memory.

Top module: `amo_unit`

## Requirements
- R1: After reset `mem_req_o`, `mem_lock_o`, `done_o`, `err_o` and `wb_en_o` are all low.
- R2: A supported request accepted on a clock edge gives a read with the lock high in the next cycle, a write (when one is due) two cycles after the read, and `done_o` high for one cycle, four cycles after the accepting edge. `mem_lock_o` is high in exactly the three cycles between acceptance and done.
- R3: Immediate low byte 0x00 adds the source value to memory, 0x40 ORs it in, 0x50 ANDs it in and 0x a0 XORs it in. Immediate bits 31:8 must be zero. Sums wrap at the operand width.
- R4: Immediate bit 0 is the fetch flag. With it set, `wb_en_o` is high at done, `wb_to_r0_o` is low and `wb_data_o` holds the memory value from before the update. With it clear, `wb_en_o` stays low.
- R5: Immediate 0xe1 (exchange) stores the source value and returns the old memory value for the source register.
- R6: Immediate 0xf1 (compare-exchange) stores the source value only if the old memory value equals R0. In both cases it raises `wb_en_o` and `wb_to_r0_o` and returns the old value, zero-extended. A failed compare issues no write, and the timing of R2 still holds.
- R7: Size code 3 selects 64-bit operands and byte enables 0xFF. Size code 0 selects 32-bit operands from the lane that address bit 2 picks: enables 0x0F when bit 2 is 0, 0xF0 when it is 1. For 32-bit operations, comparisons and results use only the low 32 bits of the source value and R0, and returned values are zero-extended. Address bits 1:0 are ignored, and for 64-bit operations bit 2 is ignored as well.
- R8: Size codes 1 and 2, immediate low bytes other than those of R3 to R6 (0xe0 and 0xf0 included), and nonzero immediate bits 31:8 all give `done_o` with `err_o` one cycle after acceptance. The error ends with no lock, no memory access and no writeback.
- R9: `start_i` is ignored while the unit is busy, and also in the cycle that `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken while idle |
| base_i | input | ADDR_W | Base byte address |
| offset_i | input | OFF_W | Signed displacement added to the base |
| size_i | input | 2 | Access-size code (0 word, 3 double-word) |
| imm_i | input | IMM_W | Operation immediate |
| src_val_i | input | DATA_W | Source register value |
| r0_val_i | input | DATA_W | R0 value, the compare operand |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the request |
| mem_addr_o | output | ADDR_W | Byte address of the access |
| mem_be_o | output | DATA_W/8 | Byte enables of a write |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after the read request |
| mem_lock_o | output | 1 | Holds the memory for the read-write window |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Unsupported request, valid with done |
| wb_en_o | output | 1 | Writeback value is valid |
| wb_to_r0_o | output | 1 | Writeback goes to R0 rather than the source register |
| wb_data_o | output | DATA_W | Old memory value, zero-extended |

## Verification
The two events that can fall in the same cycle are a new start strobe and the unit's own busy or done phase. The bench provokes this by holding `start_i` high from acceptance through the done cycle of many requests, both successful and erroneous. It judges the result at the ports: each request must produce exactly one done strobe and the expected number of memory writes, and the lock must stay low in the cycles after done. A second overlap, a failed compare that falls in the write slot, is judged by the write count and by the R0 writeback arriving in the same cycle as it would after a successful compare.

// File: rtl/amo_pkg.sv
package amo_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_MODIFY,
      ST_WRITE,
      ST_DONE
   } amo_state_e;

   typedef enum logic [2:0] {
      AOP_ADD,
      AOP_OR,
      AOP_AND,
      AOP_XOR,
      AOP_XCHG,
      AOP_CMPX
   } amo_op_e;

   typedef struct packed {
      logic    ok;
      amo_op_e op;
      logic    fetch;
      logic    dword;
   } amo_dec_t;

   localparam logic [1:0] SZ_WORD  = 2'd0;
   localparam logic [1:0] SZ_DWORD = 2'd3;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
   import amo_pkg::*;
#(
   parameter int IMM_W = 32
) (
   input  logic [1:0]       size_i,
   input  logic [IMM_W-1:0] imm_i,
   output amo_dec_t         dec_o
);

   if (IMM_W <= 8) begin : g_bad_imm
      $error("amo_decode: IMM_W must exceed 8");
   end

   logic size_ok;
   logic high_zero;
   logic code_ok;
   amo_op_e op;

   always_comb begin
      size_ok   = (size_i == SZ_WORD) || (size_i == SZ_DWORD);
      high_zero = (imm_i[IMM_W-1:8] == '0);
      code_ok   = 1'b1;
      op        = AOP_ADD;
      case (imm_i[7:0])
         8'h00, 8'h01: op = AOP_ADD;
         8'h40, 8'h41: op = AOP_OR;
         8'h50, 8'h51: op = AOP_AND;
         8'ha0, 8'ha1: op = AOP_XOR;
         8'he1:        op = AOP_XCHG;
         8'hf1:        op = AOP_CMPX;
         default:      code_ok = 1'b0;
      endcase
      dec_o.ok    = size_ok && high_zero && code_ok;
      dec_o.op    = op;
      dec_o.fetch = imm_i[0];
      dec_o.dword = (size_i == SZ_DWORD);
   end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
   import amo_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  amo_op_e           op_i,
   input  logic              dword_i,
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] src_i,
   input  logic [DATA_W-1:0] r0_i,
   output logic [DATA_W-1:0] new_o,
   output logic              match_o
);

   localparam int HALF = DATA_W / 2;

   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] b;

   always_comb begin
      mask    = dword_i ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
      b       = src_i & mask;
      match_o = (((old_i ^ r0_i) & mask) == '0);
      case (op_i)
         AOP_ADD:  new_o = (old_i + b) & mask;
         AOP_OR:   new_o = old_i | b;
         AOP_AND:  new_o = old_i & b;
         AOP_XOR:  new_o = old_i ^ b;
         default:  new_o = b;
      endcase
   end

endmodule

// File: rtl/amo_lane.sv
module amo_lane #(
   parameter int DATA_W       = 64,
   parameter bit LANE_BY_ADDR = 1'b1
) (
   input  logic                  dword_i,
   input  logic                  lane_i,
   input  logic [DATA_W-1:0]     rdata_i,
   input  logic [DATA_W-1:0]     wval_i,
   output logic [DATA_W-1:0]     old_o,
   output logic [DATA_W-1:0]     wdata_o,
   output logic [DATA_W/8-1:0]   be_o
);

   localparam int HALF = DATA_W / 2;
   localparam int BE_W = DATA_W / 8;
   localparam int HB   = BE_W / 2;

   logic hi;

   if (LANE_BY_ADDR) begin : g_addr_lane
      assign hi = lane_i;
   end else begin : g_low_lane
      logic unused_lane;
      assign unused_lane = lane_i;
      assign hi          = 1'b0;
   end

   always_comb begin
      if (dword_i) begin
         old_o   = rdata_i;
         wdata_o = wval_i;
         be_o    = {BE_W{1'b1}};
      end else begin
         old_o   = {{HALF{1'b0}}, (hi ? rdata_i[DATA_W-1:HALF] : rdata_i[HALF-1:0])};
         wdata_o = {wval_i[HALF-1:0], wval_i[HALF-1:0]};
         be_o    = hi ? {{HB{1'b1}}, {HB{1'b0}}} : {{HB{1'b0}}, {HB{1'b1}}};
      end
   end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
   import amo_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int DATA_W       = 64,
   parameter int OFF_W        = 16,
   parameter int IMM_W        = 32,
   parameter bit LANE_BY_ADDR = 1'b1
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                start_i,
   input  logic [ADDR_W-1:0]   base_i,
   input  logic [OFF_W-1:0]    offset_i,
   input  logic [1:0]          size_i,
   input  logic [IMM_W-1:0]    imm_i,
   input  logic [DATA_W-1:0]   src_val_i,
   input  logic [DATA_W-1:0]   r0_val_i,
   output logic                mem_req_o,
   output logic                mem_we_o,
   output logic [ADDR_W-1:0]   mem_addr_o,
   output logic [DATA_W/8-1:0] mem_be_o,
   output logic [DATA_W-1:0]   mem_wdata_o,
   input  logic [DATA_W-1:0]   mem_rdata_i,
   output logic                mem_lock_o,
   output logic                done_o,
   output logic                err_o,
   output logic                wb_en_o,
   output logic                wb_to_r0_o,
   output logic [DATA_W-1:0]   wb_data_o
);

   localparam int LANE_BIT = $clog2(DATA_W / 16);

   if (DATA_W != 64) begin : g_bad_data
      $error("amo_unit: DATA_W must be 64");
   end
   if (ADDR_W <= OFF_W || ADDR_W <= LANE_BIT) begin : g_bad_addr
      $error("amo_unit: ADDR_W too narrow");
   end

   amo_state_e        state_q;
   amo_dec_t          dec_q;
   amo_dec_t          dec_in;
   logic              err_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_sum;
   logic [DATA_W-1:0] src_q;
   logic [DATA_W-1:0] r0_q;
   logic [DATA_W-1:0] old_q;
   logic [DATA_W-1:0] new_q;
   logic              match_q;
   logic [DATA_W-1:0] old_lane;
   logic [DATA_W-1:0] new_val;
   logic              match_now;
   logic              write_go;

   assign addr_sum = base_i + {{(ADDR_W-OFF_W){offset_i[OFF_W-1]}}, offset_i};

   amo_decode #(.IMM_W(IMM_W)) decode_i (
      .size_i (size_i),
      .imm_i  (imm_i),
      .dec_o  (dec_in)
   );

   amo_lane #(.DATA_W(DATA_W), .LANE_BY_ADDR(LANE_BY_ADDR)) lane_i (
      .dword_i (dec_q.dword),
      .lane_i  (addr_q[LANE_BIT]),
      .rdata_i (mem_rdata_i),
      .wval_i  (new_q),
      .old_o   (old_lane),
      .wdata_o (mem_wdata_o),
      .be_o    (mem_be_o)
   );

   amo_alu #(.DATA_W(DATA_W)) alu_i (
      .op_i    (dec_q.op),
      .dword_i (dec_q.dword),
      .old_i   (old_lane),
      .src_i   (src_q),
      .r0_i    (r0_q),
      .new_o   (new_val),
      .match_o (match_now)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         dec_q   <= '0;
         err_q   <= 1'b0;
         addr_q  <= '0;
         src_q   <= '0;
         r0_q    <= '0;
         old_q   <= '0;
         new_q   <= '0;
         match_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  dec_q   <= dec_in;
                  addr_q  <= addr_sum;
                  src_q   <= src_val_i;
                  r0_q    <= r0_val_i;
                  err_q   <= !dec_in.ok;
                  state_q <= dec_in.ok ? ST_READ : ST_DONE;
               end
            end
            ST_READ:   state_q <= ST_MODIFY;
            ST_MODIFY: begin
               old_q   <= old_lane;
               new_q   <= new_val;
               match_q <= match_now;
               state_q <= ST_WRITE;
            end
            ST_WRITE:  state_q <= ST_DONE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign write_go   = (state_q == ST_WRITE) && ((dec_q.op != AOP_CMPX) || match_q);
   assign mem_lock_o = (state_q == ST_READ) || (state_q == ST_MODIFY) || (state_q == ST_WRITE);
   assign mem_req_o  = (state_q == ST_READ) || write_go;
   assign mem_we_o   = write_go;
   assign mem_addr_o = addr_q;
   assign done_o     = (state_q == ST_DONE);
   assign err_o      = done_o && err_q;
   assign wb_en_o    = done_o && !err_q && dec_q.fetch;
   assign wb_to_r0_o = done_o && !err_q && (dec_q.op == AOP_CMPX);
   assign wb_data_o  = old_q;

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
   parameter int DATA_W = 64
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                start_i,
   input logic                mem_req_o,
   input logic                mem_we_o,
   input logic [DATA_W/8-1:0] mem_be_o,
   input logic                mem_lock_o,
   input logic                done_o,
   input logic                err_o,
   input logic                wb_en_o,
   input logic                wb_to_r0_o
);

   assert_reset_quiet_R1: assert property (@(posedge clk_i)
      $rose(rst_ni) |-> !mem_lock_o && !done_o && !mem_req_o);

   assert_req_locked_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o |-> mem_lock_o);

   assert_write_after_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && mem_we_o) |-> $past(mem_lock_o, 2) && $past(mem_req_o, 2) && !$past(mem_we_o, 2));

   assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   assert_lock_from_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(mem_lock_o) |-> $past(start_i) && !$past(done_o));

   assert_err_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |-> done_o && !wb_en_o && !mem_lock_o && !mem_req_o);

   assert_r0_fetch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wb_to_r0_o |-> wb_en_o && done_o);

   assert_be_shape_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_req_o && mem_we_o) |-> (($countones(mem_be_o) == DATA_W/8) ||
                                   (mem_be_o == {{(DATA_W/16){1'b0}}, {(DATA_W/16){1'b1}}}) ||
                                   (mem_be_o == {{(DATA_W/16){1'b1}}, {(DATA_W/16){1'b0}}})));

endmodule

bind amo_unit amo_unit_chk #(.DATA_W(DATA_W)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .start_i    (start_i),
   .mem_req_o  (mem_req_o),
   .mem_we_o   (mem_we_o),
   .mem_be_o   (mem_be_o),
   .mem_lock_o (mem_lock_o),
   .done_o     (done_o),
   .err_o      (err_o),
   .wb_en_o    (wb_en_o),
   .wb_to_r0_o (wb_to_r0_o)
);

// File: tb/amo_unit_tb_top.sv
`timescale 1ns/1ps
module amo_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base = '0;
   logic [15:0] offset = '0;
   logic [1:0]  size = '0;
   logic [31:0] imm = '0;
   logic [63:0] src = '0;
   logic [63:0] r0 = '0;
   logic        mem_req, mem_we, mem_lock, done, err, wb_en, wb_to_r0;
   logic [31:0] mem_addr;
   logic [7:0]  mem_be;
   logic [63:0] mem_wdata, wb_data;
   logic [63:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   int wr_cnt = 0;
   logic [63:0] mem [16];

   always #2 clk = ~clk;

   amo_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .offset_i(offset),
      .size_i(size), .imm_i(imm), .src_val_i(src), .r0_val_i(r0),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_lock_o(mem_lock),
      .done_o(done), .err_o(err), .wb_en_o(wb_en), .wb_to_r0_o(wb_to_r0), .wb_data_o(wb_data)
   );

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            for (int b = 0; b < 8; b++)
               if (mem_be[b]) mem[mem_addr[6:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= mem[mem_addr[6:3]];
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Reference model built from the requirements
   task automatic model(input logic [1:0] sz, input logic [31:0] im, input logic [31:0] a,
                        input logic [63:0] s, input logic [63:0] z, input logic [63:0] m,
                        output bit ok, output bit en, output bit to_r0, output logic [63:0] old,
                        output bit wr, output logic [63:0] m_after);
      bit dw, hi, cmpx;
      logic [63:0] mask, b, nv;
      logic [7:0] lo = im[7:0];
      dw = (sz == 2'd3);
      hi = a[2];
      cmpx = (lo == 8'hf1);
      ok = ((sz == 2'd0) || dw) && (im[31:8] == 0) &&
           (lo inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'ha0, 8'ha1, 8'he1, 8'hf1});
      mask = dw ? '1 : 64'h0000_0000_ffff_ffff;
      old = dw ? m : {32'h0, (hi ? m[63:32] : m[31:0])};
      b = s & mask;
      case (lo[7:4])
         4'h0: nv = (old + b) & mask;
         4'h4: nv = old | b;
         4'h5: nv = old & b;
         4'ha: nv = old ^ b;
         default: nv = b;
      endcase
      wr = ok && (!cmpx || (((old ^ z) & mask) == 0));
      en = ok && lo[0];
      to_r0 = ok && cmpx;
      m_after = m;
      if (wr) begin
         if (dw) m_after = nv;
         else if (hi) m_after[63:32] = nv[31:0];
         else m_after[31:0] = nv[31:0];
      end
   endtask

   task automatic run_op(input logic [31:0] bs, input logic [15:0] of, input logic [1:0] sz,
                         input logic [31:0] im, input logic [63:0] s, input logic [63:0] z,
                         input bit hold, input string tag);
      logic [31:0] a;
      bit ok, en, to_r0, wr;
      logic [63:0] old, m_after;
      int cyc, locks, wc0;
      a = bs + {{16{of[15]}}, of};
      model(sz, im, a, s, z, mem[a[6:3]], ok, en, to_r0, old, wr, m_after);
      wc0 = wr_cnt;
      @(negedge clk);
      base = bs; offset = of; size = sz; imm = im; src = s; r0 = z; start = 1'b1;
      @(posedge clk);
      cyc = 1; locks = 0;
      @(negedge clk);
      if (!hold) start = 1'b0;
      while (!done && cyc < 20) begin
         if (mem_lock) locks++;
         @(posedge clk); cyc++;
         @(negedge clk);
      end
      chk(cyc == (ok ? 4 : 1), {tag, " R2 latency"}, cyc, ok ? 4 : 1);
      chk(locks == (ok ? 3 : 0), {tag, " R2 lock cycles"}, locks, ok ? 3 : 0);
      chk(err == !ok, {tag, " R8 error flag"}, err, !ok);
      chk(wb_en == en, {tag, " R4 writeback enable"}, wb_en, en);
      chk(wb_to_r0 == to_r0, {tag, " R6 writeback to R0"}, wb_to_r0, to_r0);
      if (en) chk(wb_data == old, {tag, " R4 old value"}, wb_data, old);
      chk(mem[a[6:3]] == m_after, {tag, " memory contents"}, mem[a[6:3]], m_after);
      chk((wr_cnt - wc0) == (wr ? 1 : 0), {tag, " write count"}, wr_cnt - wc0, wr ? 1 : 0);
      if (hold) begin
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         chk(!mem_lock && !done, {tag, " R9 start in done cycle ignored"}, {mem_lock, done}, 0);
         @(posedge clk);
         @(negedge clk);
         chk(!mem_lock && (wr_cnt - wc0) == (wr ? 1 : 0), {tag, " R9 no extra access"}, wr_cnt - wc0, wr ? 1 : 0);
      end
   endtask

   initial begin
      #(4.0 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int unsigned seed;
      logic [7:0] codes [14] = '{8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'ha0, 8'ha1,
                                 8'he1, 8'hf1, 8'he0, 8'hf0, 8'h02, 8'h31};
      logic [1:0] sizes [6] = '{2'd0, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2};
      seed = $urandom(32'h5eed_0042);
      for (int i = 0; i < 16; i++) mem[i] = {$urandom, $urandom};
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!mem_req && !mem_lock && !done && !err && !wb_en, "R1 reset outputs", {mem_req, mem_lock, done, err, wb_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!mem_lock && !done, "R1 idle after reset", {mem_lock, done}, 0);

      // Directed corners
      mem[1] = 64'hffff_ffff_ffff_fff0;
      run_op(32'h8, 16'h0, 2'd3, 32'h01, 64'h20, 0, 0, "R3 add wrap 64");
      mem[2] = 64'h1234_5678_ffff_fffe;
      run_op(32'h14, 16'hfffc, 2'd0, 32'h00, 64'hdead_0000_0000_0005, 0, 0, "R7 word add low lane");
      run_op(32'h14, 16'h0, 2'd0, 32'h41, 64'h0000_0001_8000_0000, 0, 0, "R7 word or high lane");
      run_op(32'h18, 16'h0, 2'd3, 32'h51, 64'h0f0f_0f0f_0f0f_0f0f, 0, 0, "R3 and fetch");
      run_op(32'h18, 16'h0, 2'd3, 32'ha0, 64'hffff_0000_ffff_0000, 0, 0, "R4 xor no fetch");
      run_op(32'h20, 16'h0, 2'd3, 32'he1, 64'hcafe_f00d_1234_5678, 0, 0, "R5 exchange");
      mem[5] = 64'h0000_0000_0000_0077;
      run_op(32'h28, 16'h0, 2'd3, 32'hf1, 64'h99, 64'h77, 0, "R6 cmpxchg match");
      run_op(32'h28, 16'h0, 2'd3, 32'hf1, 64'h55, 64'h77, 0, "R6 cmpxchg mismatch");
      mem[6] = 64'habcd_0000_0000_0042;
      run_op(32'h30, 16'h0, 2'd0, 32'hf1, 64'h11, 64'hffff_0000_0000_0042, 0, "R7 word cmpxchg upper ignored");
      run_op(32'h30, 16'h0, 2'd1, 32'h00, 64'h1, 0, 0, "R8 size 1");
      run_op(32'h30, 16'h0, 2'd2, 32'h01, 64'h1, 0, 0, "R8 size 2");
      run_op(32'h30, 16'h0, 2'd3, 32'he0, 64'h1, 0, 0, "R8 exchange without fetch");
      run_op(32'h30, 16'h0, 2'd3, 32'h100, 64'h1, 0, 0, "R8 upper immediate bits");
      run_op(32'h38, 16'h0, 2'd3, 32'h01, 64'h3, 0, 1, "R9 start held");
      run_op(32'h38, 16'h0, 2'd0, 32'hf0, 64'h3, 0, 1, "R9 start held on error");

      // Random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] bs, im;
         logic [15:0] of;
         logic [1:0] sz;
         logic [63:0] s, z, m;
         logic [31:0] a;
         bs = $urandom & 32'hffff_fffc;
         of = 16'($urandom);
         sz = sizes[$urandom % 6];
         im = {(($urandom % 20) == 0) ? 24'h1 : 24'h0, codes[$urandom % 14]};
         s = {$urandom, $urandom};
         z = {$urandom, $urandom};
         a = bs + {{16{of[15]}}, of};
         m = mem[a[6:3]];
         if ($urandom % 2) z = (sz == 2'd3) ? m : {z[63:32], (a[2] ? m[63:32] : m[31:0])};
         run_op(bs, of, sz, im, s, z, ($urandom % 4) == 0, "R3 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule